// File: doc/BRIEF.md
# Banked ROM/RAM Mapper Controller

This block sits between a CPU bus and cartridge storage. It watches CPU write cycles that land in the low half of the address space and treats them as control writes. Those writes set a RAM gate, a low ROM bank field, a two-bit upper field and a mode bit. From this state it forms the physical ROM address for the fixed window at 0x0000–0x3FFF and for the switchable window at 0x4000–0x7FFF. It also forms the physical RAM address for the 8 KiB window at 0xA000–0xBFFF, and drives a RAM chip enable.

The upper field is placed above the low field, 5 bit positions up by default or 4 when the multicart input is set. When the mode bit is 1, the upper field also picks the bank seen in the fixed window and the RAM bank. Bank numbers that go past the configured ROM or RAM size wrap by masking. A switchable bank that wraps to 0 is turned into bank 1.

The address outputs are combinational from the current CPU address and the stored registers. A control write takes effect on the clock edge where it is sampled.

Top module: `mbc_mapper`

## Requirements
- R1: After reset the switchable window maps bank 1, the fixed window maps bank 0, the RAM bank is 0 and the RAM chip enable stays low.
- R2: A write to region 0 (address bits [15:13] = 0) with data 0x0A enables RAM, and one with 0x00 disables it; any other data leaves the gate unchanged. `ram_ce` is high only when RAM is enabled, `cpu_cs` is high and the address is in 0xA000–0xBFFF.
- R3: A write to region 1 loads data bits [4:0] into the low bank field, and a written value of 0 is stored as 1.
- R4: With `cfg_multicart` high, the low field is masked to 4 bits after the zero substitution, and the upper field sits at bit 4 of the bank number. With mode 1 it also picks fixed bank upper<<4.
- R5: A write to region 2 loads data bits [1:0] into the upper field, placed at bit 5 of the switchable bank number in the default stride. A write to either field keeps the other field.
- R6: A write to region 3 sets mode to data bit 0. With mode 1 the fixed window maps bank upper<<stride and the RAM bank equals the upper field.
- R7: With mode 0 the fixed window maps bank 0 and the RAM bank is 0.
- R8: A switchable bank number at or above 2^`cfg_rom_lg` is masked by 2^`cfg_rom_lg`−1. If that result is 0 it becomes 1.
- R9: The fixed-window bank number is masked by 2^`cfg_rom_lg`−1, with no substitution of zero.
- R10: The RAM bank is masked by 2^`cfg_ram_lg`−1.
- R11: `rom_addr` = bank×0x4000 + address bits [13:0], using the fixed bank when address bit 14 is 0 and the switchable bank when it is 1. `ram_addr` = RAM bank×0x2000 + address bits [12:0].
- R12: Writes with address bit 15 set change no mapping state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wdata | input | 8 | CPU write data |
| cpu_we | input | 1 | Write strobe, one cycle per write |
| cpu_cs | input | 1 | A bus access (read or write) is in progress |
| cfg_rom_lg | input | 3 | log2 of the ROM size in 16 KiB banks (1 to BANK_W) |
| cfg_ram_lg | input | 2 | log2 of the RAM size in 8 KiB banks (0 to RBANK_W) |
| cfg_multicart | input | 1 | Selects the stride of 4 instead of 5 |
| rom_addr | output | ROM_AW | Physical ROM address |
| ram_addr | output | RAM_AW | Physical RAM address |
| ram_ce | output | 1 | RAM chip enable |

## Verification
The assertions assume that the configuration inputs stay static while the block is running. They also assume that `cfg_rom_lg` is at least 1 and at most the ROM bank width, that `cfg_ram_lg` is at most the RAM bank width, and that `cpu_we` is a single-cycle strobe. The stimulus changes the configuration only between writes. Before it clears `cfg_multicart`, it rewrites the low field with a nonzero value, so that no zero low field left over from a multicart scenario is seen in the default stride. Every configuration value it applies stays inside the stated ranges.

// File: rtl/mbc_pkg.sv
// Shared constants for the mapper controller.
// Assumes a 16-bit CPU address space with control writes in 0x0000-0x7FFF.
package mbc_pkg;
    typedef enum logic [2:0] {
        RGN_RAMEN = 3'd0,
        RGN_LOW   = 3'd1,
        RGN_UPPER = 3'd2,
        RGN_MODE  = 3'd3
    } wr_region_e;

    localparam logic [2:0] RAM_WINDOW   = 3'd5;
    localparam logic [7:0] RAM_ON_CODE  = 8'h0A;
    localparam logic [7:0] RAM_OFF_CODE = 8'h00;
    localparam int LOW_W       = 5;
    localparam int UP_W        = 2;
    localparam int RAW_W       = LOW_W + UP_W;
    localparam int STRIDE_STD  = 5;
    localparam int STRIDE_MC   = 4;
    localparam int ROM_SPAN_LG = 14;
    localparam int RAM_SPAN_LG = 13;
endpackage

// File: rtl/mbc_bank_regs.sv
// Control-write decoder and bank-select registers.
// Assumes wr_en is a single-cycle strobe and multicart is static.
module mbc_bank_regs
    import mbc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [2:0]       wr_rgn,
    input  logic [7:0]       wr_data,
    input  logic             multicart,
    output logic             ram_en,
    output logic [LOW_W-1:0] low_q,
    output logic [UP_W-1:0]  up_q,
    output logic             mode_q
);
    logic [LOW_W-1:0] low_next;

    // Condition the low field: zero becomes one, then apply the stride width.
    always_comb begin
        low_next = wr_data[LOW_W-1:0];
        if (low_next == '0)
            low_next = LOW_W'(1);
        if (multicart)
            low_next[LOW_W-1] = 1'b0;
    end

    // Register update on decoded control writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_en <= 1'b0;
            low_q  <= LOW_W'(1);
            up_q   <= '0;
            mode_q <= 1'b0;
        end else if (wr_en) begin
            case (wr_rgn)
                RGN_RAMEN: begin
                    if (wr_data == RAM_ON_CODE)
                        ram_en <= 1'b1;
                    else if (wr_data == RAM_OFF_CODE)
                        ram_en <= 1'b0;
                end
                RGN_LOW:   low_q  <= low_next;
                RGN_UPPER: up_q   <= wr_data[UP_W-1:0];
                RGN_MODE:  mode_q <= wr_data[0];
                default: ;
            endcase
        end
    end

    AST_LOW_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !multicart |-> (low_q != '0)); // R3
    AST_EN_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_rgn == RGN_RAMEN && wr_data != RAM_ON_CODE && wr_data != RAM_OFF_CODE)
        |=> $stable(ram_en)); // R2
    AST_LOW_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_rgn == RGN_UPPER) |=> $stable(low_q)); // R5
    AST_UP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_rgn == RGN_LOW) |=> $stable(up_q)); // R5
endmodule

// File: rtl/mbc_rom_map.sv
// Forms the fixed and switchable ROM bank numbers and picks one per access.
// Assumes 1 <= rom_lg <= BANK_W and static configuration.
module mbc_rom_map
    import mbc_pkg::*;
#(
    parameter int BANK_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LOW_W-1:0]  low,
    input  logic [UP_W-1:0]   up,
    input  logic              mode,
    input  logic              multicart,
    input  logic [2:0]        rom_lg,
    input  logic              hi_window,
    output logic [BANK_W-1:0] bank
);
    logic [RAW_W-1:0] up_shift, sw_raw, sw_masked, sw_fin, fix_fin, size_mask;
    logic             sw_over;

    // Place the upper field at the configured stride.
    always_comb begin
        up_shift = multicart ? (RAW_W'(up) << STRIDE_MC) : (RAW_W'(up) << STRIDE_STD);
        sw_raw   = up_shift | RAW_W'(low);
    end

    // Wrap by ROM size and substitute bank 1 for a wrapped zero.
    always_comb begin
        size_mask = (RAW_W'(1) << rom_lg) - RAW_W'(1);
        sw_over   = (sw_raw >> rom_lg) != '0;
        sw_masked = sw_raw & size_mask;
        sw_fin    = (sw_over && sw_masked == '0) ? RAW_W'(1) : sw_masked;
        fix_fin   = mode ? (up_shift & size_mask) : '0;
    end

    // Select the bank for the window being addressed.
    always_comb bank = hi_window ? BANK_W'(sw_fin) : BANK_W'(fix_fin);

    AST_SW_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !multicart |-> (sw_fin != '0)); // R8
    AST_SW_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_lg != '0) |-> ((sw_fin >> rom_lg) == '0)); // R8
    AST_FIX_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (fix_fin >> rom_lg) == '0); // R9
    AST_FIX_MODE0: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |-> (fix_fin == '0)); // R7
endmodule

// File: rtl/mbc_ram_map.sv
// Forms the RAM bank number from the upper field and mode bit.
// Assumes ram_lg <= RBANK_W and static configuration.
module mbc_ram_map
    import mbc_pkg::*;
#(
    parameter int RBANK_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [UP_W-1:0]    up,
    input  logic               mode,
    input  logic [1:0]         ram_lg,
    output logic [RBANK_W-1:0] rbank
);
    logic [UP_W-1:0] sel, mask, wrapped;

    // Pick the RAM bank by mode, then wrap by RAM size.
    always_comb begin
        sel     = mode ? up : '0;
        mask    = (UP_W'(1) << ram_lg) - UP_W'(1);
        wrapped = sel & mask;
        rbank   = RBANK_W'(wrapped);
    end

    AST_RB_FITS: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_lg < 2'd2) |-> ((wrapped >> ram_lg) == '0)); // R10
    AST_RB_MODE0: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |-> (rbank == '0)); // R7
endmodule

// File: rtl/mbc_mapper.sv
// Top of the banked ROM/RAM mapper controller.
// Decodes control writes, holds the bank state and forms the physical addresses.
// Assumes the cfg_* inputs are static and cpu_we is a one-cycle strobe.
module mbc_mapper
    import mbc_pkg::*;
#(
    parameter int ROM_AW = 21,
    parameter int RAM_AW = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic [7:0]        cpu_wdata,
    input  logic              cpu_we,
    input  logic              cpu_cs,
    input  logic [2:0]        cfg_rom_lg,
    input  logic [1:0]        cfg_ram_lg,
    input  logic              cfg_multicart,
    output logic [ROM_AW-1:0] rom_addr,
    output logic [RAM_AW-1:0] ram_addr,
    output logic              ram_ce
);
    localparam int BANK_W  = ROM_AW - ROM_SPAN_LG;
    localparam int RBANK_W = RAM_AW - RAM_SPAN_LG;

    logic               ctl_wr, ram_en, mode_q;
    logic [LOW_W-1:0]   low_q;
    logic [UP_W-1:0]    up_q;
    logic [BANK_W-1:0]  rom_bank;
    logic [RBANK_W-1:0] ram_bank;

    // Control writes live only in the lower half of the address space.
    always_comb ctl_wr = cpu_we && !cpu_addr[15];

    mbc_bank_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr), .wr_rgn(cpu_addr[15:13]),
        .wr_data(cpu_wdata), .multicart(cfg_multicart), .ram_en(ram_en),
        .low_q(low_q), .up_q(up_q), .mode_q(mode_q)
    );

    mbc_rom_map #(.BANK_W(BANK_W)) u_rom (
        .clk(clk), .rst_n(rst_n), .low(low_q), .up(up_q), .mode(mode_q),
        .multicart(cfg_multicart), .rom_lg(cfg_rom_lg), .hi_window(cpu_addr[14]),
        .bank(rom_bank)
    );

    mbc_ram_map #(.RBANK_W(RBANK_W)) u_ram (
        .clk(clk), .rst_n(rst_n), .up(up_q), .mode(mode_q), .ram_lg(cfg_ram_lg),
        .rbank(ram_bank)
    );

    // Join the bank numbers with the in-window offsets and gate the RAM.
    always_comb begin
        rom_addr = {rom_bank, cpu_addr[ROM_SPAN_LG-1:0]};
        ram_addr = {ram_bank, cpu_addr[RAM_SPAN_LG-1:0]};
        ram_ce   = ram_en && cpu_cs && (cpu_addr[15:13] == RAM_WINDOW);
    end

    AST_OFF_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr[15:13] == 3'd0 && cpu_wdata == RAM_OFF_CODE) |=> !ram_ce); // R2
    AST_HI_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr[15])
        |=> ($stable(low_q) && $stable(up_q) && $stable(mode_q) && $stable(ram_en))); // R12
endmodule

// File: tb/mbc_mapper_tb.sv
module mbc_mapper_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic        cpu_we = 1'b0;
    logic        cpu_cs = 1'b0;
    logic [2:0]  cfg_rom_lg = 3'd7;
    logic [1:0]  cfg_ram_lg = 2'd2;
    logic        cfg_multicart = 1'b0;
    logic [20:0] rom_addr;
    logic [14:0] ram_addr;
    logic        ram_ce;
    int total = 0;
    int bad = 0;
    int cycles = 0;

    mbc_mapper u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
        .cpu_we(cpu_we), .cpu_cs(cpu_cs), .cfg_rom_lg(cfg_rom_lg),
        .cfg_ram_lg(cfg_ram_lg), .cfg_multicart(cfg_multicart),
        .rom_addr(rom_addr), .ram_addr(ram_addr), .ram_ce(ram_ce)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1; cpu_cs = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0; cpu_cs = 1'b0;
    endtask

    task automatic look(input logic [15:0] a, input logic cs);
        cpu_addr = a; cpu_cs = cs;
        #1;
    endtask

    task automatic t_reset;
        look(16'h4123, 1'b0); chk("R1 switchable bank 1", 32'(rom_addr), 32'h04123);
        look(16'h0123, 1'b0); chk("R1 fixed bank 0", 32'(rom_addr), 32'h00123);
        look(16'hA005, 1'b1); chk("R1 ram disabled", 32'(ram_ce), 32'h0);
        chk("R11 ram addr bank 0", 32'(ram_addr), 32'h0005);
    endtask

    task automatic t_ram_gate;
        wr(16'h0000, 8'h0A);
        look(16'hA010, 1'b1); chk("R2 enabled", 32'(ram_ce), 32'h1);
        look(16'hBFFF, 1'b1); chk("R2 top of window", 32'(ram_ce), 32'h1);
        look(16'hC000, 1'b1); chk("R2 above window", 32'(ram_ce), 32'h0);
        look(16'h9FFF, 1'b1); chk("R2 below window", 32'(ram_ce), 32'h0);
        look(16'hA010, 1'b0); chk("R2 no access", 32'(ram_ce), 32'h0);
        wr(16'h1FFF, 8'h05);
        look(16'hA010, 1'b1); chk("R2 other value keeps gate", 32'(ram_ce), 32'h1);
        wr(16'h0000, 8'h00);
        look(16'hA010, 1'b1); chk("R2 disabled", 32'(ram_ce), 32'h0);
        wr(16'h0000, 8'h0A);
    endtask

    task automatic t_low;
        wr(16'h2000, 8'h00);
        look(16'h4000, 1'b0); chk("R3 zero becomes one", 32'(rom_addr), 32'h04000);
        wr(16'h3FFF, 8'h13);
        look(16'h7FFF, 1'b0); chk("R3 bank 0x13", 32'(rom_addr), 32'h4FFFF);
        wr(16'h2000, 8'hE7);
        look(16'h4001, 1'b0); chk("R3 only bits 4:0", 32'(rom_addr), 32'h1C001);
    endtask

    task automatic t_upper;
        wr(16'h4000, 8'h02);
        look(16'h4000, 1'b0); chk("R5 upper at bit 5 keeps low", 32'(rom_addr), 32'h11C000);
        wr(16'h2000, 8'h01);
        look(16'h4000, 1'b0); chk("R5 low write keeps upper", 32'(rom_addr), 32'h104000);
        look(16'h0010, 1'b0); chk("R7 fixed stays 0 in mode 0", 32'(rom_addr), 32'h00010);
    endtask

    task automatic t_mode;
        wr(16'h6000, 8'h01);
        look(16'h0010, 1'b0); chk("R6 fixed bank from upper", 32'(rom_addr), 32'h100010);
        look(16'hA003, 1'b1); chk("R6 ram bank from upper", 32'(ram_addr), 32'h4003);
        look(16'h4000, 1'b0); chk("R6 switchable unchanged", 32'(rom_addr), 32'h104000);
        wr(16'h6000, 8'h00);
        look(16'h0010, 1'b0); chk("R7 fixed back to 0", 32'(rom_addr), 32'h00010);
        look(16'hA003, 1'b1); chk("R7 ram bank 0", 32'(ram_addr), 32'h0003);
    endtask

    task automatic t_ignored;
        wr(16'hA000, 8'h00);
        look(16'hA000, 1'b1); chk("R12 gate unchanged", 32'(ram_ce), 32'h1);
        wr(16'hA000, 8'h13);
        look(16'h4000, 1'b0); chk("R12 bank unchanged", 32'(rom_addr), 32'h104000);
    endtask

    task automatic t_rom_wrap;
        cfg_rom_lg = 3'd5;
        look(16'h4000, 1'b0); chk("R8 0x41 wraps to 1", 32'(rom_addr), 32'h04000);
        wr(16'h2000, 8'h03);
        look(16'h4000, 1'b0); chk("R8 0x43 wraps to 3", 32'(rom_addr), 32'h0C000);
        wr(16'h6000, 8'h01);
        look(16'h0100, 1'b0); chk("R9 fixed 0x40 wraps to 0", 32'(rom_addr), 32'h00100);
        cfg_rom_lg = 3'd6;
        wr(16'h4000, 8'h03);
        look(16'h0100, 1'b0); chk("R9 fixed 0x60 wraps to 0x20", 32'(rom_addr), 32'h80100);
        look(16'h4000, 1'b0); chk("R8 0x63 wraps to 0x23", 32'(rom_addr), 32'h8C000);
        wr(16'h6000, 8'h00);
        cfg_rom_lg = 3'd7;
    endtask

    task automatic t_multicart;
        cfg_multicart = 1'b1;
        wr(16'h2000, 8'h05);
        look(16'h4000, 1'b0); chk("R4 upper at bit 4", 32'(rom_addr), 32'hD4000);
        wr(16'h2000, 8'h15);
        look(16'h4000, 1'b0); chk("R4 low masked to 4 bits", 32'(rom_addr), 32'hD4000);
        wr(16'h4000, 8'h00);
        wr(16'h2000, 8'h10);
        look(16'h4000, 1'b0); chk("R4 masked low 0 in range", 32'(rom_addr), 32'h00000);
        wr(16'h4000, 8'h01);
        wr(16'h6000, 8'h01);
        look(16'h0000, 1'b0); chk("R4 fixed bank 0x10", 32'(rom_addr), 32'h40000);
        cfg_rom_lg = 3'd4;
        look(16'h4000, 1'b0); chk("R8 wrapped zero becomes 1", 32'(rom_addr), 32'h04000);
        wr(16'h6000, 8'h00);
        wr(16'h2000, 8'h01);
        cfg_rom_lg = 3'd7;
        cfg_multicart = 1'b0;
    endtask

    task automatic t_ram_wrap;
        wr(16'h4000, 8'h03);
        wr(16'h6000, 8'h01);
        look(16'hA000, 1'b1); chk("R10 bank 3 of 4", 32'(ram_addr), 32'h6000);
        look(16'hBFFF, 1'b1); chk("R11 ram offset", 32'(ram_addr), 32'h7FFF);
        cfg_ram_lg = 2'd1;
        look(16'hA000, 1'b1); chk("R10 wraps to 1", 32'(ram_addr), 32'h2000);
        cfg_ram_lg = 2'd0;
        look(16'hA000, 1'b1); chk("R10 single bank", 32'(ram_addr), 32'h0000);
        cfg_ram_lg = 2'd2;
        wr(16'h6000, 8'h00);
    endtask

    always @(posedge clk) cycles <= cycles + 1;

    initial begin
        wait (cycles > 20000);
        bad++; total++;
        $display("FAIL watchdog act=%0d exp=done", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ram_gate();
        t_low();
        t_upper();
        t_mode();
        t_ignored();
        t_rom_wrap();
        t_multicart();
        t_ram_wrap();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule